// File: doc/BRIEF.md
# Second-Order Low-Pass IIR Section (Canonical Form)

This block is one second-order recursive filter section in the canonical arrangement. A single two-deep delay line holds the intermediate node and serves both the feedback (pole) and feedforward (zero) paths. The coefficients are fixed at elaboration. They come from a second-order maximally flat low-pass prototype mapped to discrete time with the bilinear substitution at unit sample period. The DC gain of the section is very close to one.

Each cycle in which `valid_i` is high takes one signed Q1.15 sample. The section updates its two state words and, one clock later, presents the output sample with `valid_o` high. When `valid_i` is low the state is frozen and the output register holds its last value. Samples may therefore arrive in bursts or with gaps of any length.

Top module: `biquad_df2`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it is released, `valid_o` is 0, `y_o` is 0 and both state words are 0. After a reset in the middle of a run, the next sample is filtered as if it were the first.
- R2: `valid_o` is high exactly one clock after each cycle in which `valid_i` is high, and low otherwise. `y_o` changes only on a clock that raises or keeps `valid_o` high. Otherwise it holds its previous value.
- R3: A cycle with `valid_i` low leaves both state words unchanged. An output sequence with idle gaps inserted equals the same sequence sent without gaps.
- R4: The intermediate node is w = x·2^15 + 33695·w1 − 11964·w2, where x is the input as a signed integer and w1, w2 are Q.15 state integers. The sum is rounded to Q.15 by adding 2^14 and shifting right arithmetically by 15, then clamped to the signed 22-bit range.
- R5: The output is y = 2759·w + 5518·w1 + 2759·w2, rounded in the same way (add 2^14, arithmetic shift right by 15).
- R6: After reset, a single sample x followed by zeros gives round(2759·x / 2^15) as the first output. With x = 32767 that output is 2759.
- R7: An output beyond the 16-bit range saturates to 32767 (0x7FFF) or −32768 (0x8000). A full-scale positive step overshoots and reaches 32767. A step from +full scale to −full scale reaches −32768.
- R8: A constant input of 16384 settles to an output within 2 LSB of 16384.
- R9: On every accepted sample the older state word takes the previous value of the newer one, and the newer one takes the new w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample strobe |
| x_i | input | 16 | Input sample, signed Q1.15 |
| valid_o | output | 1 | Output sample strobe, one clock after valid_i |
| y_o | output | 16 | Output sample, signed Q1.15, rounded and saturated |

## Verification
The hardest condition to reach from the ports is output saturation. The section's gain is about one, so an in-range input never leaves the 16-bit range except through the step overshoot of the pole pair. The stimulus holds full scale long enough for that overshoot to build, then swings from positive to negative full scale to drive the opposite limit. Freezing the state is exercised by a pseudo-random stream with random idle gaps, scored against a gap-free model. A reset in the middle of a run confirms that the following impulse starts from clean state.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int DATA_W_D  = 16;
  localparam int COEF_W_D  = 18;
  localparam int ACC_W_D   = 40;
  localparam int STATE_W_D = 22;
  localparam int FRAC_W_D  = 15;
  // Q2.15 integer coefficients; feedback terms stored as magnitudes
  localparam int B0_Q_D = 2759;
  localparam int B1_Q_D = 5518;
  localparam int A1_Q_D = 33695;
  localparam int A2_Q_D = 11964;
endpackage

// File: rtl/biquad_round_sat.sv
module biquad_round_sat #(
  parameter int IN_W  = 40,
  parameter int OUT_W = 16,
  parameter int SHIFT = 15
) (
  input  logic signed [IN_W-1:0]  acc_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam logic signed [IN_W-1:0] HALF = IN_W'(1) <<< (SHIFT-1);
  localparam logic signed [IN_W-1:0] MAXV = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = ~MAXV;
  localparam logic signed [OUT_W-1:0] MAX_O = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_O = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] rs;

  always_comb begin
    rs = (acc_i + HALF) >>> SHIFT;
    if (rs > MAXV)      res_o = MAX_O;
    else if (rs < MINV) res_o = MIN_O;
    else                res_o = rs[OUT_W-1:0];
  end
endmodule

// File: rtl/biquad_fb.sv
module biquad_fb #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 18,
  parameter int STATE_W = 22,
  parameter int ACC_W   = 40,
  parameter int FRAC_W  = 15,
  parameter int A1_Q    = 33695,
  parameter int A2_Q    = 11964
) (
  input  logic signed [DATA_W-1:0]  x_i,
  input  logic signed [STATE_W-1:0] w1_i,
  input  logic signed [STATE_W-1:0] w2_i,
  output logic signed [ACC_W-1:0]   acc_o
);
  localparam logic signed [COEF_W-1:0] A1_C = COEF_W'(A1_Q);
  localparam logic signed [COEF_W-1:0] A2_C = COEF_W'(A2_Q);
  localparam logic signed [ACC_W-1:0]  A1_E = ACC_W'(A1_C);
  localparam logic signed [ACC_W-1:0]  A2_E = ACC_W'(A2_C);

  logic signed [ACC_W-1:0] x_e, w1_e, w2_e;

  assign x_e  = {{(ACC_W-DATA_W){x_i[DATA_W-1]}}, x_i};
  assign w1_e = {{(ACC_W-STATE_W){w1_i[STATE_W-1]}}, w1_i};
  assign w2_e = {{(ACC_W-STATE_W){w2_i[STATE_W-1]}}, w2_i};

  // poles: denominator 1 - a1 z^-1 + a2 z^-2
  assign acc_o = (x_e <<< FRAC_W) + A1_E * w1_e - A2_E * w2_e;
endmodule

// File: rtl/biquad_ff.sv
module biquad_ff #(
  parameter int COEF_W  = 18,
  parameter int STATE_W = 22,
  parameter int ACC_W   = 40,
  parameter int B0_Q    = 2759,
  parameter int B1_Q    = 5518
) (
  input  logic signed [STATE_W-1:0] w0_i,
  input  logic signed [STATE_W-1:0] w1_i,
  input  logic signed [STATE_W-1:0] w2_i,
  output logic signed [ACC_W-1:0]   acc_o
);
  localparam logic signed [COEF_W-1:0] B0_C = COEF_W'(B0_Q);
  localparam logic signed [COEF_W-1:0] B1_C = COEF_W'(B1_Q);
  localparam logic signed [ACC_W-1:0]  B0_E = ACC_W'(B0_C);
  localparam logic signed [ACC_W-1:0]  B1_E = ACC_W'(B1_C);

  logic signed [ACC_W-1:0] w0_e, w1_e, w2_e;

  assign w0_e = {{(ACC_W-STATE_W){w0_i[STATE_W-1]}}, w0_i};
  assign w1_e = {{(ACC_W-STATE_W){w1_i[STATE_W-1]}}, w1_i};
  assign w2_e = {{(ACC_W-STATE_W){w2_i[STATE_W-1]}}, w2_i};

  generate
    if (B1_Q == 2 * B0_Q) begin : g_shared
      // symmetric numerator with b1 = 2*b0: single multiplier
      assign acc_o = B0_E * (w0_e + (w1_e <<< 1) + w2_e);
    end else begin : g_full
      assign acc_o = B0_E * (w0_e + w2_e) + B1_E * w1_e;
    end
  endgenerate
endmodule

// File: rtl/biquad_df2.sv
module biquad_df2
  import biquad_pkg::*;
#(
  parameter int DATA_W  = DATA_W_D,
  parameter int COEF_W  = COEF_W_D,
  parameter int ACC_W   = ACC_W_D,
  parameter int STATE_W = STATE_W_D,
  parameter int FRAC_W  = FRAC_W_D,
  parameter int B0_Q    = B0_Q_D,
  parameter int B1_Q    = B1_Q_D,
  parameter int A1_Q    = A1_Q_D,
  parameter int A2_Q    = A2_Q_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o
);
  logic signed [STATE_W-1:0] w1_q, w2_q, w_new;
  logic signed [ACC_W-1:0]   fb_acc, ff_acc;
  logic signed [DATA_W-1:0]  y_new;

  biquad_fb #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .STATE_W(STATE_W), .ACC_W(ACC_W),
    .FRAC_W(FRAC_W), .A1_Q(A1_Q), .A2_Q(A2_Q)
  ) u_fb (
    .x_i  (x_i),
    .w1_i (w1_q),
    .w2_i (w2_q),
    .acc_o(fb_acc)
  );

  biquad_round_sat #(.IN_W(ACC_W), .OUT_W(STATE_W), .SHIFT(FRAC_W)) u_w_rs (
    .acc_i(fb_acc),
    .res_o(w_new)
  );

  biquad_ff #(
    .COEF_W(COEF_W), .STATE_W(STATE_W), .ACC_W(ACC_W), .B0_Q(B0_Q), .B1_Q(B1_Q)
  ) u_ff (
    .w0_i (w_new),
    .w1_i (w1_q),
    .w2_i (w2_q),
    .acc_o(ff_acc)
  );

  biquad_round_sat #(.IN_W(ACC_W), .OUT_W(DATA_W), .SHIFT(FRAC_W)) u_y_rs (
    .acc_i(ff_acc),
    .res_o(y_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q    <= '0;
      w2_q    <= '0;
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        w2_q <= w1_q;
        w1_q <= w_new;
        y_o  <= y_new;
      end
    end
  end
endmodule

// File: rtl/biquad_df2_chk.sv
module biquad_df2_chk #(
  parameter int DATA_W  = 16,
  parameter int STATE_W = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               valid_o,
  input logic [DATA_W-1:0]  y_o,
  input logic [STATE_W-1:0] w1_q,
  input logic [STATE_W-1:0] w2_q
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!valid_o && y_o == '0 && w1_q == '0 && w2_q == '0));

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  // R2
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> $stable(y_o));

  // R3
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> ($stable(w1_q) && $stable(w2_q)));

  // R9
  state_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i)) |-> (w2_q == $past(w1_q)));
endmodule

bind biquad_df2 biquad_df2_chk #(.DATA_W(DATA_W), .STATE_W(STATE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .valid_o(valid_o),
  .y_o    (y_o),
  .w1_q   (w1_q),
  .w2_q   (w2_q)
);

// File: tb/biquad_df2_bench.sv
module biquad_df2_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] x_i = '0;
  logic        valid_o;
  logic [15:0] y_o;

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;

  longint m_w1 = 0, m_w2 = 0;
  int exp_q[$];
  int last_y = 0;
  int max_y = -40000, min_y = 40000;

  always #4 clk_i = ~clk_i;

  biquad_df2 u_biquad_df2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .x_i    (x_i),
    .valid_o(valid_o),
    .y_o    (y_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R4 R5 R9 reference computed from the stated formulas
  task automatic model(input int x, output int y);
    longint acc, w, ya, yr;
    acc = (longint'(x) <<< 15) + 64'sd33695 * m_w1 - 64'sd11964 * m_w2;
    w = (acc + 16384) >>> 15;
    if (w > 2097151) w = 2097151;
    if (w < -2097152) w = -2097152;
    ya = 64'sd2759 * w + 64'sd5518 * m_w1 + 64'sd2759 * m_w2;
    yr = (ya + 16384) >>> 15;
    if (yr > 32767) yr = 32767;
    if (yr < -32768) yr = -32768;
    y = int'(yr);
    m_w2 = m_w1;
    m_w1 = w;
  endtask

  task automatic send(input int x, input int gap);
    int y;
    @(negedge clk_i);
    valid_i = 1'b1;
    x_i = 16'(x);
    model(x, y);
    exp_q.push_back(y);
    repeat (gap) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (running && rst_ni) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected valid_o", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check("R4 R5 R9 sample", int'($signed(y_o)), e);
        end
        last_y = int'($signed(y_o));
        if (last_y > max_y) max_y = last_y;
        if (last_y < min_y) min_y = last_y;
      end else begin
        check("R2 hold", int'($signed(y_o)), last_y);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    m_w1 = 0;
    m_w2 = 0;
    last_y = 0;
    exp_q.delete();
    @(negedge clk_i);
    check("R1 reset y_o", int'(y_o), 0);
    check("R1 reset valid_o", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    check("R1 reset y_o", int'(y_o), 0);
    check("R1 reset valid_o", int'(valid_o), 0);
    rst_ni = 1'b1;
    running = 1'b1;

    // R6 impulse response first sample
    send(32767, 0);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R6 impulse first", int'($signed(y_o)), 2759);
    for (int i = 0; i < 30; i++) send(0, 0);
    idle(3);

    // R8 DC gain
    do_reset();
    for (int i = 0; i < 60; i++) send(16384, 0);
    idle(3);
    check("R8 settle", (last_y >= 16382 && last_y <= 16386) ? 1 : 0, 1);

    // R7 saturation in both directions
    do_reset();
    max_y = -40000;
    min_y = 40000;
    for (int i = 0; i < 40; i++) send(32767, 0);
    idle(2);
    check("R7 positive clip", max_y, 32767);
    for (int i = 0; i < 40; i++) send(-32768, 0);
    idle(2);
    check("R7 negative clip", min_y, -32768);

    // R3 R2 pseudo-random stream with idle gaps
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'($signed(lfsr)) >>> 1, int'(lfsr[2:0]) % 4);
    end
    idle(3);
    check("R3 queue drained", exp_q.size(), 0);

    // R1 reset mid-run then fresh impulse
    for (int i = 0; i < 5; i++) send(20000, 0);
    do_reset();
    send(16384, 0);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R1 R6 post-reset first", int'($signed(y_o)), 1380);
    idle(3);

    running = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule